// File: doc/BRIEF.md
# Register-Mapped Two-Wire Bus Target

This block answers as a target on a two-wire serial bus (I2C) with an open-drain data line. It watches the clock and data lines through synchronisers in its own system clock domain. It pulls the data line low only to acknowledge a byte or to send a zero bit. It answers one 7-bit device address, which is given on an input pin. Behind that address sits a small bank of byte registers, reached through a register pointer.

A write transaction loads the pointer from its first data byte. Each later byte goes into the register the pointer selects, and the pointer then advances. A read transaction streams bytes out from the current pointer, which also advances after each byte. The pointer survives a repeated start. A controller can therefore write the register index, issue a repeated start, and read that register back. Local logic reaches the same registers through a simple side port: a combinational read address and a write strobe. The number of registers is a power-of-two parameter.

Top module: `i2c_reg_target`

## Requirements
- R1: A start is seen when SDA falls while SCL is high, and a stop when SDA rises while SCL is high, both on the synchronised lines. Either one, at any point, drops a partly received byte without writing a register. After a start the block waits for an address byte.
- R2: After a start, the block shifts in 7 address bits, most significant bit first, followed by a direction bit where 1 means read. If the address equals `devAddr`, the block pulls SDA low for the whole ninth clock.
- R3: If the address does not match, the block releases SDA and ignores the bus until the next start or stop. Later bytes of that transaction are not acknowledged and do not change any register.
- R4: In a write transaction, the first data byte loads the pointer from its low bits. Each later byte is stored in the register the pointer selects. Every data byte is acknowledged by pulling SDA low on its ninth clock.
- R5: In a read transaction, the block sends the byte at the pointer, most significant bit first, and releases SDA for the ninth clock. If the controller acknowledges (SDA low), the next byte follows. If it does not (SDA high), the block stops driving the bus.
- R6: The pointer advances by one after each data byte that is stored or sent. From the last register it wraps to register 0.
- R7: The pointer keeps its value across a start, a repeated start and a stop. A read with no preceding pointer byte starts at the value the pointer already holds.
- R8: The block changes its SDA drive only after SCL has been seen low. The drive stays constant while SCL is high.
- R9: The side port returns `regFile[locAddr]` combinationally. A cycle with `locWrEn` high writes `locWrData` into that register.
- R10: After reset, SDA is released, all registers read zero and the pointer is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| devAddr | input | 7 | Device address the block answers to |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaPullLow | output | 1 | 1 pulls the data line low; 0 releases it |
| locAddr | input | log2(NUM_REGS) | Side-port register index |
| locWrEn | input | 1 | Side-port write strobe |
| locWrData | input | 8 | Side-port write data |
| locRdData | output | 8 | Side-port read data for `locAddr` |

## Verification
The bench drives the bus in several ways:
- Write transactions of one and two data bytes, one of which crosses the end of the register bank. These separate the pointer byte from the data bytes and show the wrap.
- A pointer write, then a repeated start, then a two-byte read ended by a NACK. This shows that the pointer is kept across the repeated start, that bytes leave most significant bit first, and that the block releases the bus after the NACK.
- Transactions to a foreign address, in both directions. The expected result is high acknowledge bits and unchanged registers.
- A stop and a start placed in the middle of a byte. These show that a partial byte is dropped and that the block recovers straight away.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } tgtStateT;

  typedef enum logic [1:0] {
    DRV_REL,
    DRV_ACK,
    DRV_DATA
  } sdaDrvT;

  // Synchronised bus levels and the events derived from them
  typedef struct packed {
    logic sclHigh;
    logic sclWasHigh;
    logic sdaLevel;
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
  } busEvT;

  // Control-to-datapath strobes
  typedef struct packed {
    logic shiftIn;
    logic rxBit;
    logic loadPtr;
    logic writeReg;
    logic incPtr;
    logic loadTx;
    logic shiftTx;
  } dpStrobeT;

endpackage

// File: rtl/i2ct_line_sync.sv
module i2ct_line_sync
  import i2ct_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  sclIn,
  input  logic  sdaIn,
  output busEvT ev
);

  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;

  for (genvar st = 0; st < STAGES; st++) begin : g_stage
    if (st == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe[0] <= 1'b1;
          sdaPipe[0] <= 1'b1;
        end else begin
          sclPipe[0] <= sclIn;
          sdaPipe[0] <= sdaIn;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe[st] <= 1'b1;
          sdaPipe[st] <= 1'b1;
        end else begin
          sclPipe[st] <= sclPipe[st-1];
          sdaPipe[st] <= sdaPipe[st-1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclPipe[STAGES-1];
      sdaPrev <= sdaPipe[STAGES-1];
    end
  end

  logic sclNow;
  logic sdaNow;
  assign sclNow = sclPipe[STAGES-1];
  assign sdaNow = sdaPipe[STAGES-1];

  always_comb begin
    ev.sclHigh    = sclNow;
    ev.sclWasHigh = sclPrev;
    ev.sdaLevel   = sdaNow;
    ev.sclRise    = sclNow && !sclPrev;
    ev.sclFall    = !sclNow && sclPrev;
    ev.startSeen  = sclNow && sclPrev && sdaPrev && !sdaNow;
    ev.stopSeen   = sclNow && sclPrev && !sdaPrev && sdaNow;
  end

endmodule

// File: rtl/i2ct_ctrl.sv
module i2ct_ctrl
  import i2ct_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  busEvT      ev,
  input  logic [6:0] devAddr,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  output dpStrobeT   stb,
  output logic       sdaPullLow
);

  localparam logic [3:0] BYTE_BITS = 4'd8;

  tgtStateT   state;
  sdaDrvT     drv;
  logic [3:0] bitCnt;
  logic       ptrPhase;
  logic       mstAck;
  logic       byteDone;
  logic       addrHit;

  assign byteDone = (bitCnt == BYTE_BITS);
  assign addrHit  = (rxByte[7:1] == devAddr);

  // Strobes to the datapath; a start or stop suppresses them
  always_comb begin
    stb = '0;
    if (!ev.startSeen && !ev.stopSeen) begin
      if (ev.sclRise && !byteDone && (state == ST_ADDR || state == ST_WR)) begin
        stb.shiftIn = 1'b1;
        stb.rxBit   = ev.sdaLevel;
      end
      if (ev.sclFall) begin
        unique case (state)
          ST_WR: if (byteDone) begin
            stb.loadPtr  = ptrPhase;
            stb.writeReg = !ptrPhase;
            stb.incPtr   = !ptrPhase;
          end
          ST_ADDR_ACK: stb.loadTx = rxByte[0];
          ST_RD: begin
            stb.shiftTx = !byteDone;
            stb.incPtr  = byteDone;
          end
          ST_RD_ACK: stb.loadTx = mstAck;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      drv      <= DRV_REL;
      bitCnt   <= '0;
      ptrPhase <= 1'b0;
      mstAck   <= 1'b0;
    end else if (ev.startSeen) begin
      state    <= ST_ADDR;
      drv      <= DRV_REL;
      bitCnt   <= '0;
      ptrPhase <= 1'b1;
    end else if (ev.stopSeen) begin
      state <= ST_IDLE;
      drv   <= DRV_REL;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (ev.sclRise && !byteDone) bitCnt <= bitCnt + 4'd1;
          if (ev.sclFall && byteDone) begin
            if (addrHit) begin
              state <= ST_ADDR_ACK;
              drv   <= DRV_ACK;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: if (ev.sclFall) begin
          bitCnt <= '0;
          if (rxByte[0]) begin
            state <= ST_RD;
            drv   <= DRV_DATA;
          end else begin
            state <= ST_WR;
            drv   <= DRV_REL;
          end
        end
        ST_WR: begin
          if (ev.sclRise && !byteDone) bitCnt <= bitCnt + 4'd1;
          if (ev.sclFall && byteDone) begin
            state    <= ST_WR_ACK;
            drv      <= DRV_ACK;
            ptrPhase <= 1'b0;
          end
        end
        ST_WR_ACK: if (ev.sclFall) begin
          state  <= ST_WR;
          drv    <= DRV_REL;
          bitCnt <= '0;
        end
        ST_RD: begin
          if (ev.sclRise && !byteDone) bitCnt <= bitCnt + 4'd1;
          if (ev.sclFall && byteDone) begin
            state  <= ST_RD_ACK;
            drv    <= DRV_REL;
            mstAck <= 1'b0;
          end
        end
        ST_RD_ACK: begin
          if (ev.sclRise) mstAck <= !ev.sdaLevel;
          if (ev.sclFall) begin
            if (mstAck) begin
              state  <= ST_RD;
              drv    <= DRV_DATA;
              bitCnt <= '0;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sdaPullLow = (drv == DRV_ACK) || (drv == DRV_DATA && !txBit);

  AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (ev.sclHigh && ev.sclWasHigh) |-> $stable(sdaPullLow)); // R8

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaPullLow); // R3

  AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    ev.startSeen |=> (state == ST_ADDR) && (bitCnt == 4'd0)); // R1

  AST_ADDR_ACK_PULLS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR_ACK) |-> sdaPullLow); // R2

endmodule

// File: rtl/i2ct_regfile_dp.sv
module i2ct_regfile_dp
  import i2ct_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dpStrobeT                    stb,
  input  logic                        startSeen,
  input  logic [$clog2(NUM_REGS)-1:0] locAddr,
  input  logic                        locWrEn,
  input  logic [7:0]                  locWrData,
  output logic [7:0]                  locRdData,
  output logic [7:0]                  rxByte,
  output logic                        txBit
);

  localparam int PTR_W = $clog2(NUM_REGS);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(NUM_REGS - 1);

  logic [7:0]       regFile [NUM_REGS];
  logic [7:0]       rxShift;
  logic [7:0]       txShift;
  logic [PTR_W-1:0] ptr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxShift <= '0;
    else if (stb.shiftIn) rxShift <= {rxShift[6:0], stb.rxBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ptr <= '0;
    else if (stb.loadPtr) ptr <= rxShift[PTR_W-1:0];
    else if (stb.incPtr) ptr <= (ptr == LAST_IDX) ? '0 : ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txShift <= 8'hFF;
    else if (stb.loadTx) txShift <= regFile[ptr];
    else if (stb.shiftTx) txShift <= {txShift[6:0], 1'b1};
  end

  // One write port per register: bus write wins over a side-port write
  for (genvar idx = 0; idx < NUM_REGS; idx++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regFile[idx] <= '0;
      else if (stb.writeReg && ptr == PTR_W'(idx)) regFile[idx] <= rxShift;
      else if (locWrEn && locAddr == PTR_W'(idx)) regFile[idx] <= locWrData;
    end
  end

  assign locRdData = regFile[locAddr];
  assign rxByte    = rxShift;
  assign txBit     = txShift[7];

  AST_PTR_WRAPS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.incPtr && !stb.loadPtr && ptr == LAST_IDX) |=> (ptr == '0)); // R6

  AST_BUS_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    stb.writeReg |=> (regFile[$past(ptr)] == $past(rxShift))); // R4

  AST_PTR_KEPT_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> (ptr == $past(ptr))); // R7

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2ct_pkg::*;
#(
  parameter int NUM_REGS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [6:0]                  devAddr,
  input  logic                        sclIn,
  input  logic                        sdaIn,
  output logic                        sdaPullLow,
  input  logic [$clog2(NUM_REGS)-1:0] locAddr,
  input  logic                        locWrEn,
  input  logic [7:0]                  locWrData,
  output logic [7:0]                  locRdData
);

  busEvT      ev;
  dpStrobeT   stb;
  logic [7:0] rxByte;
  logic       txBit;

  i2ct_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rstN  (rstN),
    .sclIn (sclIn),
    .sdaIn (sdaIn),
    .ev    (ev)
  );

  i2ct_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ev         (ev),
    .devAddr    (devAddr),
    .rxByte     (rxByte),
    .txBit      (txBit),
    .stb        (stb),
    .sdaPullLow (sdaPullLow)
  );

  i2ct_regfile_dp #(.NUM_REGS(NUM_REGS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .startSeen (ev.startSeen),
    .locAddr   (locAddr),
    .locWrEn   (locWrEn),
    .locWrData (locWrData),
    .locRdData (locRdData),
    .rxByte    (rxByte),
    .txBit     (txBit)
  );

endmodule

// File: tb/sim_i2c_reg_target.sv
module sim_i2c_reg_target;

  localparam int NREG = 16;
  localparam int QTR  = 10;
  localparam logic [6:0] MY_ADDR = 7'h3A;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclLine = 1'b1;
  logic       sdaDrv = 1'b1;
  logic       sdaPullLow;
  logic       sdaBus;
  logic [3:0] locAddr = '0;
  logic       locWrEn = 1'b0;
  logic [7:0] locWrData = '0;
  logic [7:0] locRdData;

  always #4 clk = ~clk;

  assign sdaBus = sdaDrv & ~sdaPullLow;

  i2c_reg_target #(.NUM_REGS(NREG)) u0 (
    .clk        (clk),
    .rstN       (rstN),
    .devAddr    (MY_ADDR),
    .sclIn      (sclLine),
    .sdaIn      (sdaBus),
    .sdaPullLow (sdaPullLow),
    .locAddr    (locAddr),
    .locWrEn    (locWrEn),
    .locWrData  (locWrData),
    .locRdData  (locRdData)
  );

  typedef struct {
    logic [7:0] v;
    string      tag;
  } itemT;

  itemT       expQ[$];
  itemT       obsQ[$];
  int         nCmp = 0;
  int         nBad = 0;
  int         r8Viol = 0;
  logic [7:0] model [NREG];
  bit         finished = 1'b0;

  // Scoreboard monitor
  always @(negedge clk) begin
    while (obsQ.size() > 0 && expQ.size() > 0) begin : cmp
      itemT e;
      itemT o;
      e = expQ.pop_front();
      o = obsQ.pop_front();
      nCmp++;
      if (o.v !== e.v) begin
        nBad++;
        $display("FAIL %s: actual %02h expected %02h", e.tag, o.v, e.v);
      end
    end
  end

  // R8 watch: drive must not move while SCL is high
  logic sclPrev = 1'b1;
  logic pullPrev = 1'b0;
  always @(negedge clk) begin
    if (rstN && sclLine && sclPrev && (sdaPullLow !== pullPrev)) r8Viol++;
    sclPrev  = sclLine;
    pullPrev = sdaPullLow;
  end

  task automatic waitQ(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expectItem(input logic [7:0] v, input string tag);
    itemT it;
    it.v = v;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic observe(input logic [7:0] v);
    itemT it;
    it.v = v;
    it.tag = "";
    obsQ.push_back(it);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1;  waitQ(QTR);
    sclLine = 1'b1; waitQ(QTR);
    sdaDrv = 1'b0;  waitQ(QTR);
    sclLine = 1'b0; waitQ(QTR);
  endtask

  task automatic busStop();
    sdaDrv = 1'b0;  waitQ(QTR);
    sclLine = 1'b1; waitQ(QTR);
    sdaDrv = 1'b1;  waitQ(QTR);
  endtask

  task automatic busBit(input logic b, output logic r);
    sdaDrv = b;     waitQ(QTR);
    sclLine = 1'b1; waitQ(QTR);
    r = sdaBus;     waitQ(QTR);
    sclLine = 1'b0; waitQ(QTR);
  endtask

  task automatic sendByte(input logic [7:0] b, input logic expAck, input string tag);
    logic r;
    for (int i = 7; i >= 0; i--) busBit(b[i], r);
    busBit(1'b1, r);
    expectItem({7'b0, expAck}, tag);
    observe({7'b0, r});
  endtask

  task automatic recvByte(input logic [7:0] expV, input logic ackBit, input string tag);
    logic [7:0] d;
    logic r;
    for (int i = 7; i >= 0; i--) begin
      busBit(1'b1, r);
      d[i] = r;
    end
    busBit(ackBit, r);
    expectItem(expV, tag);
    observe(d);
  endtask

  task automatic checkReg(input int idx, input string tag);
    locAddr = 4'(idx);
    waitQ(1);
    expectItem(model[idx], tag);
    observe(locRdData);
  endtask

  task automatic localWrite(input int idx, input logic [7:0] v);
    locAddr = 4'(idx);
    locWrData = v;
    locWrEn = 1'b1;
    waitQ(1);
    locWrEn = 1'b0;
    model[idx] = v;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin : driver
    logic r;
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    waitQ(5);
    rstN = 1'b1;
    waitQ(3);

    // R10: reset state
    expectItem(8'h00, "R10 sda released after reset");
    observe({7'b0, sdaPullLow});
    checkReg(0, "R10 reg0 zero");
    checkReg(9, "R10 reg9 zero");

    // R9: side-port write then read
    localWrite(3, 8'h5C);
    checkReg(3, "R9 side write reg3");
    localWrite(4, 8'h3C);

    // R2 R4: write pointer 2 then data A5
    busStart();
    sendByte({MY_ADDR, 1'b0}, 1'b0, "R2 address ack");
    sendByte(8'h02, 1'b0, "R4 pointer ack");
    sendByte(8'hA5, 1'b0, "R4 data ack");
    busStop();
    model[2] = 8'hA5;
    checkReg(2, "R4 reg2 written");
    checkReg(3, "R4 reg3 untouched");

    // R7 R5 R6: pointer write, repeated start, read two bytes
    busStart();
    sendByte({MY_ADDR, 1'b0}, 1'b0, "R2 address ack");
    sendByte(8'h02, 1'b0, "R4 pointer ack");
    busStart();
    sendByte({MY_ADDR, 1'b1}, 1'b0, "R2 read address ack");
    recvByte(8'hA5, 1'b0, "R7 read after repeated start");
    recvByte(8'h5C, 1'b1, "R6 pointer advanced on read");
    recvByte(8'hFF, 1'b1, "R5 released after nack");
    busStop();

    // R7: read with no pointer byte continues at pointer 4
    busStart();
    sendByte({MY_ADDR, 1'b1}, 1'b0, "R2 read address ack");
    recvByte(8'h3C, 1'b1, "R7 pointer kept across stop");
    busStop();

    // R6: write across the end of the bank
    busStart();
    sendByte({MY_ADDR, 1'b0}, 1'b0, "R2 address ack");
    sendByte(8'h0F, 1'b0, "R4 pointer ack");
    sendByte(8'h11, 1'b0, "R4 data ack");
    sendByte(8'h22, 1'b0, "R6 wrapped data ack");
    busStop();
    model[15] = 8'h11;
    model[0]  = 8'h22;
    checkReg(15, "R6 last reg");
    checkReg(0, "R6 wrapped to reg0");

    // R3: foreign address, write then read
    busStart();
    sendByte({7'h11, 1'b0}, 1'b1, "R3 no ack foreign address");
    sendByte(8'h07, 1'b1, "R3 pointer ignored");
    sendByte(8'h99, 1'b1, "R3 data ignored");
    busStop();
    checkReg(7, "R3 reg7 unchanged");
    busStart();
    sendByte({7'h3B, 1'b1}, 1'b1, "R3 no ack foreign read");
    recvByte(8'hFF, 1'b1, "R3 bus left released");
    busStop();

    // R1: stop in the middle of a data byte
    busStart();
    sendByte({MY_ADDR, 1'b0}, 1'b0, "R2 address ack");
    sendByte(8'h06, 1'b0, "R4 pointer ack");
    for (int i = 0; i < 4; i++) busBit(1'b1, r);
    busStop();
    checkReg(6, "R1 partial byte dropped at stop");

    // R1: start in the middle of a data byte, then a clean write
    busStart();
    sendByte({MY_ADDR, 1'b0}, 1'b0, "R2 address ack");
    sendByte(8'h08, 1'b0, "R4 pointer ack");
    for (int i = 0; i < 3; i++) busBit(1'b0, r);
    busStart();
    sendByte({MY_ADDR, 1'b0}, 1'b0, "R1 address ack after restart");
    sendByte(8'h09, 1'b0, "R4 pointer ack");
    sendByte(8'h99, 1'b0, "R4 data ack");
    busStop();
    model[9] = 8'h99;
    checkReg(8, "R1 partial byte dropped at start");
    checkReg(9, "R1 recovered write");

    // R8: drive stable across every SCL high phase
    waitQ(2);
    expectItem(8'h00, "R8 drive changes while SCL high");
    observe(r8Viol[7:0]);

    waitQ(5);
    if (expQ.size() != 0 || obsQ.size() != 0) begin
      nBad++;
      $display("FAIL scoreboard: actual %0d left expected 0", expQ.size() + obsQ.size());
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule